// File: doc/BRIEF.md
# Register-File Field Scan Engine

This block searches a 128-byte, byte-addressable register file for a value one, two or four bytes wide. A single 32-bit control word describes the search: where to begin, how many fields to examine, how wide each field is and how far apart consecutive fields start. Because the step between fields is set apart from the field width, a multi-byte pattern can be found at any byte alignment, for example a two-byte value checked at every byte position.

After a one-cycle start pulse the engine examines one field per clock. It reads the register file through a four-lane byte port and assembles the field little-endian from consecutive bytes. When it finds the value, exhausts the field count or would step past the end of the file, it raises a one-cycle done pulse and presents a result word. The result reports the match offset and how many fields were still unexamined, so software can resume the search just past a hit by bumping the offset by one and dropping the count by one.

Top module: `fscan_engine`

## Requirements
- R1: Control byte 0 is the start offset, byte 1 the field count, byte 2 the width code (1 selects one byte, 2 selects two bytes, any other value selects four bytes) and byte 3 the stride code (1, 2 or 3 step by that many bytes, any other value steps by four).
- R2: A field is the little-endian value of the width's bytes beginning at its offset, the byte at the offset being least significant; only the low width bytes of the match value take part in the comparison.
- R3: When no field matches, result byte 0 is 0xFF and result byte 1 is 0.
- R4: On a match, result byte 0 is the byte offset of the first matching field and result byte 1 is the number of fields not yet examined, counting the matching one.
- R5: Result bytes 2 and 3 equal control bytes 2 and 3 of the accepted start.
- R6: Restarting with the offset raised by one and the count lowered by one finds the next occurrence after a previous hit.
- R7: A field count of 0 completes one cycle after start with 0xFF in byte 0 and 0 in byte 1.
- R8: A field whose last byte would lie at or beyond byte 128 ends the scan as a no-match, even if fields remain.
- R9: One field is examined per cycle; done rises the cycle after the deciding field, so done appears N+1 cycles after the start cycle when N fields were examined, and stays high for exactly one cycle.
- R10: A start pulse while a scan is in progress is ignored and does not alter the running scan or its result.
- R11: After reset done is low and the result is 0; the result holds its value between completions.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| start | input | 1 | One-cycle request to begin a scan |
| ctrlWord | input | 32 | Offset, count, width code and stride code |
| matchVal | input | 32 | Value searched for, low bytes significant |
| rfAddr | output | 7 | Byte offset of the field under test |
| rfData | input | 32 | Bytes at rfAddr to rfAddr+3, lowest address in bits 7:0 |
| done | output | 1 | One-cycle completion pulse |
| result | output | 32 | Match offset, remaining count, echoed control bytes |

## Verification
The checker watches on every cycle that done lasts a single cycle, that a no-match result always carries a zero count, that a hit reports an offset inside the file with a non-zero count, that the upper result bytes echo the accepted start, that a zero count finishes at once and that the result holds between completions. Whether the right field was found, the little-endian assembly, the count left after a hit, the resume sequence, the end-of-file cut-off and the exact latency against the number of fields examined depend on the register-file contents, so only the bench scenarios with their reference model can show them. The ignored start during a busy scan is shown by the bench by observing that no extra completion and no altered result appear.

// File: rtl/fscan_pkg.sv
package fscan_pkg;

  // number of byte lanes on the register-file read port (widest field)
  localparam int FIELD_LANES = 4;
  localparam int LANE_SEL_W  = $clog2(FIELD_LANES) + 1;

  typedef enum logic {
    ST_IDLE,
    ST_RUN
  } scanState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic load;      // capture the control word and match value
    logic step;      // advance to the next field
    logic finHit;    // finish with the current field as the match
    logic finMiss;   // finish without a match
    logic finEmpty;  // finish at once for a zero field count
  } scanStrobe_t;

  // status from datapath to control
  typedef struct packed {
    logic hit;        // current field equals the match value
    logic pastEnd;    // current field would leave the register file
    logic lastField;  // current field is the final one to examine
    logic emptyReq;   // requested field count is zero
  } scanFlags_t;

  function automatic logic [LANE_SEL_W-1:0] decodeWidth(input logic [7:0] code);
    case (code)
      8'd1:    return LANE_SEL_W'(1);
      8'd2:    return LANE_SEL_W'(2);
      default: return LANE_SEL_W'(4);
    endcase
  endfunction

  function automatic logic [LANE_SEL_W-1:0] decodeStride(input logic [7:0] code);
    case (code)
      8'd1:    return LANE_SEL_W'(1);
      8'd2:    return LANE_SEL_W'(2);
      8'd3:    return LANE_SEL_W'(3);
      default: return LANE_SEL_W'(4);
    endcase
  endfunction

endpackage

// File: rtl/fscan_control.sv
module fscan_control
  import fscan_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        start,
  input  scanFlags_t  flags,
  output scanStrobe_t strobe
);

  scanState_t state, nextState;

  always_comb begin
    strobe    = '0;
    nextState = state;
    case (state)
      ST_IDLE: begin
        if (start) begin
          if (flags.emptyReq) begin
            strobe.finEmpty = 1'b1;
          end else begin
            strobe.load = 1'b1;
            nextState   = ST_RUN;
          end
        end
      end
      ST_RUN: begin
        // leaving the file outranks any comparison on garbage bytes
        if (flags.pastEnd) begin
          strobe.finMiss = 1'b1;
          nextState      = ST_IDLE;
        end else if (flags.hit) begin
          strobe.finHit = 1'b1;
          nextState     = ST_IDLE;
        end else if (flags.lastField) begin
          strobe.finMiss = 1'b1;
          nextState      = ST_IDLE;
        end else begin
          strobe.step = 1'b1;
        end
      end
      default: nextState = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= nextState;
  end

endmodule

// File: rtl/fscan_datapath.sv
module fscan_datapath
  import fscan_pkg::*;
#(
  parameter int RF_BYTES = 128,
  parameter int ADDR_W   = $clog2(RF_BYTES)
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  scanStrobe_t              strobe,
  input  logic [31:0]              ctrlWord,
  input  logic [31:0]              matchVal,
  output logic [ADDR_W-1:0]        rfAddr,
  input  logic [8*FIELD_LANES-1:0] rfData,
  output scanFlags_t               flags,
  output logic                     done,
  output logic [31:0]              result
);

  localparam int   POS_W    = 9;
  localparam logic [POS_W-1:0] RF_LIMIT = POS_W'(RF_BYTES);
  localparam logic [7:0]       NO_MATCH = 8'hFF;

  logic [7:0]            curOff;
  logic [7:0]            remain;
  logic [LANE_SEL_W-1:0] widthSel;
  logic [LANE_SEL_W-1:0] strideSel;
  logic [31:0]           matchReg;
  logic [15:0]           upperReg;
  logic [31:0]           resultReg;
  logic                  doneReg;

  logic [FIELD_LANES-1:0] laneOk;
  logic [POS_W-1:0]       endPos;

  // per-lane compare; lanes beyond the field width always agree
  for (genvar g = 0; g < FIELD_LANES; g++) begin : gLane
    assign laneOk[g] = (rfData[8*g +: 8] == matchReg[8*g +: 8]) ||
                       (LANE_SEL_W'(g) >= widthSel);
  end

  assign endPos = {1'b0, curOff} + POS_W'(widthSel);
  assign rfAddr = curOff[ADDR_W-1:0];

  assign flags.hit       = &laneOk;
  assign flags.pastEnd   = endPos > RF_LIMIT;
  assign flags.lastField = remain == 8'd1;
  assign flags.emptyReq  = ctrlWord[15:8] == 8'd0;

  // scan position and search parameters
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      curOff    <= '0;
      remain    <= '0;
      widthSel  <= '0;
      strideSel <= '0;
      matchReg  <= '0;
      upperReg  <= '0;
    end else if (strobe.load) begin
      curOff    <= ctrlWord[7:0];
      remain    <= ctrlWord[15:8];
      widthSel  <= decodeWidth(ctrlWord[23:16]);
      strideSel <= decodeStride(ctrlWord[31:24]);
      matchReg  <= matchVal;
      upperReg  <= ctrlWord[31:16];
    end else if (strobe.step) begin
      curOff <= curOff + 8'(strideSel);
      remain <= remain - 8'd1;
    end
  end

  // completion pulse and held result
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      doneReg   <= 1'b0;
      resultReg <= '0;
    end else begin
      doneReg <= strobe.finHit | strobe.finMiss | strobe.finEmpty;
      if (strobe.finHit)
        resultReg <= {upperReg, remain, curOff};
      else if (strobe.finMiss)
        resultReg <= {upperReg, 8'd0, NO_MATCH};
      else if (strobe.finEmpty)
        resultReg <= {ctrlWord[31:16], 8'd0, NO_MATCH};
    end
  end

  assign done   = doneReg;
  assign result = resultReg;

endmodule

// File: rtl/fscan_engine.sv
module fscan_engine
  import fscan_pkg::*;
#(
  parameter  int RF_BYTES = 128,
  localparam int ADDR_W   = $clog2(RF_BYTES)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic [31:0]       ctrlWord,
  input  logic [31:0]       matchVal,
  output logic [ADDR_W-1:0] rfAddr,
  input  logic [31:0]       rfData,
  output logic              done,
  output logic [31:0]       result
);

  scanStrobe_t strobe;
  scanFlags_t  flags;

  fscan_control uCtrl (
    .clk    (clk),
    .rstN   (rstN),
    .start  (start),
    .flags  (flags),
    .strobe (strobe)
  );

  fscan_datapath #(
    .RF_BYTES (RF_BYTES),
    .ADDR_W   (ADDR_W)
  ) uDp (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .ctrlWord (ctrlWord),
    .matchVal (matchVal),
    .rfAddr   (rfAddr),
    .rfData   (rfData),
    .flags    (flags),
    .done     (done),
    .result   (result)
  );

endmodule

// File: rtl/fscan_checker.sv
module fscan_checker #(
  parameter int RF_BYTES = 128
) (
  input logic        clk,
  input logic        rstN,
  input logic        start,
  input logic [31:8] ctrlHigh,
  input logic        done,
  input logic [31:0] result
);

  logic        busy;
  logic [15:0] savedUpper;
  logic        accepted;

  // the engine is idle whenever no scan is open or the open one is reporting
  assign accepted = start && (!busy || done);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busy       <= 1'b0;
      savedUpper <= '0;
    end else if (accepted) begin
      busy       <= ctrlHigh[15:8] != 8'd0;
      savedUpper <= ctrlHigh[31:16];
    end else if (done) begin
      busy <= 1'b0;
    end
  end

  a_r9_done_single: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  a_r3_miss_zero_count: assert property (@(posedge clk) disable iff (!rstN)
    (done && result[7:0] == 8'hFF) |-> result[15:8] == 8'd0);

  a_r4_hit_in_file: assert property (@(posedge clk) disable iff (!rstN)
    (done && result[7:0] != 8'hFF) |->
      (32'(result[7:0]) < RF_BYTES) && (result[15:8] != 8'd0));

  a_r5_upper_echo: assert property (@(posedge clk) disable iff (!rstN)
    done |-> result[31:16] == savedUpper);

  a_r7_empty_immediate: assert property (@(posedge clk) disable iff (!rstN)
    (accepted && ctrlHigh[15:8] == 8'd0) |=> (done && result[15:0] == 16'h00FF));

  a_r11_result_held: assert property (@(posedge clk) disable iff (!rstN)
    !done |-> $stable(result));

endmodule

bind fscan_engine fscan_checker #(.RF_BYTES(RF_BYTES)) uChk (
  .clk      (clk),
  .rstN     (rstN),
  .start    (start),
  .ctrlHigh (ctrlWord[31:8]),
  .done     (done),
  .result   (result)
);

// File: tb/fscan_engine_test.sv
module fscan_engine_test;

  localparam int RF_BYTES = 128;

  logic        clk = 1'b0;
  logic        rstN;
  logic        start;
  logic [31:0] ctrlWord;
  logic [31:0] matchVal;
  logic [6:0]  rfAddr;
  logic [31:0] rfData;
  logic        done;
  logic [31:0] result;

  always #10 clk = ~clk;  // 50 MHz

  fscan_engine #(.RF_BYTES(RF_BYTES)) uut (
    .clk      (clk),
    .rstN     (rstN),
    .start    (start),
    .ctrlWord (ctrlWord),
    .matchVal (matchVal),
    .rfAddr   (rfAddr),
    .rfData   (rfData),
    .done     (done),
    .result   (result)
  );

  logic [7:0] mem [RF_BYTES];

  always_comb begin
    for (int k = 0; k < 4; k++) begin
      int idx;
      idx = int'(rfAddr) + k;
      rfData[8*k +: 8] = (idx < RF_BYTES) ? mem[idx] : 8'h00;
    end
  end

  typedef struct {
    logic [31:0] res;
    int          lat;
    string       tag;
  } expItem_t;

  expItem_t    expQ[$];
  int          vectors = 0;
  int          miscompares = 0;
  int          cyc = 0;
  int          issueCyc = 0;
  logic [31:0] lastResult = '0;
  bit          finished = 0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic expect32(input string req, input string what,
                          input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // reference behaviour taken from the requirements
  function automatic void refScan(input logic [31:0] c, input logic [31:0] m,
                                  output logic [31:0] r, output int lat);
    int off, n, w, s;
    bit same;
    off = int'(c[7:0]);
    n   = int'(c[15:8]);
    w   = (c[23:16] == 8'd1) ? 1 : (c[23:16] == 8'd2) ? 2 : 4;
    s   = (c[31:24] >= 8'd1 && c[31:24] <= 8'd3) ? int'(c[31:24]) : 4;
    r   = {c[31:16], 8'h00, 8'hFF};
    lat = 1;
    for (int k = 0; k < n; k++) begin
      lat = k + 2;
      if (off + w > RF_BYTES) return;
      same = 1;
      for (int b = 0; b < w; b++)
        if (mem[off + b] != m[8*b +: 8]) same = 0;
      if (same) begin
        r = {c[31:16], 8'(n - k), 8'(off)};
        return;
      end
      off += s;
    end
  endfunction

  // driver: push the expectation, pulse start, wait for the monitor to drain
  task automatic issue(input logic [31:0] c, input logic [31:0] m,
                       input string tag, input bit busyPoke);
    expItem_t e;
    refScan(c, m, e.res, e.lat);
    e.tag = tag;
    expQ.push_back(e);
    @(negedge clk);
    start    = 1'b1;
    ctrlWord = c;
    matchVal = m;
    issueCyc = cyc;
    @(negedge clk);
    if (busyPoke) begin
      // a zero-count request would finish at once if it were accepted
      ctrlWord = 32'h0102_0000;
      matchVal = 32'h0;
      @(negedge clk);
    end
    start = 1'b0;
    while (expQ.size() != 0) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  // monitor
  always @(negedge clk) begin
    if (rstN && done) begin
      expItem_t e;
      if (expQ.size() == 0) begin
        vectors++;
        miscompares++;
        $display("FAIL R10 unexpected completion: actual=%h expected=none", result);
      end else begin
        e = expQ.pop_front();
        expect32(e.tag, "result", result, e.res);
        expect32(e.tag, "latency R9", 32'(cyc - issueCyc), 32'(e.lat));
        lastResult = result;
      end
    end
  end

  task automatic finishRun();
    if (!finished) begin
      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    vectors++;
    miscompares++;
    $display("FAIL watchdog: actual=hung expected=finished");
    finishRun();
  end

  initial begin
    logic [31:0] c;
    for (int i = 0; i < RF_BYTES; i++) mem[i] = 8'(i * 5 + 1);
    mem[37] = 8'h7F; mem[38] = 8'h03;
    mem[50] = 8'h7F; mem[51] = 8'h03;
    mem[64] = 8'h40;
    mem[80] = 8'h11; mem[81] = 8'h22; mem[82] = 8'h33; mem[83] = 8'h44;

    rstN = 1'b0; start = 1'b0; ctrlWord = '0; matchVal = '0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    expect32("R11", "done after reset", 32'(done), 32'd0);
    expect32("R11", "result after reset", result, 32'd0);

    // R4 R2 R10: two-byte value at odd alignment, start poked while busy
    c = {8'd1, 8'd2, 8'd60, 8'd5};
    issue(c, 32'h0000_037F, "R4", 1'b1);
    expect32("R4", "hand hit at 37", lastResult, {16'h0102, 8'd28, 8'd37});
    repeat (4) @(negedge clk);
    expect32("R10", "result unchanged by ignored start", result, {16'h0102, 8'd28, 8'd37});

    // R6: resume just past the hit
    c = {c[31:16], lastResult[15:8] - 8'd1, lastResult[7:0] + 8'd1};
    issue(c, 32'h0000_037F, "R6", 1'b0);
    expect32("R6", "hand resume hit at 50", lastResult, {16'h0102, 8'd15, 8'd50});

    // R2: four-byte little-endian field, and reversed order must not match
    issue({8'd4, 8'd4, 8'd40, 8'd0}, 32'h4433_2211, "R2", 1'b0);
    expect32("R2", "hand le hit", lastResult, {16'h0404, 8'd20, 8'd80});
    issue({8'd4, 8'd4, 8'd1, 8'd80}, 32'h1122_3344, "R2", 1'b0);
    expect32("R3", "reversed bytes miss", lastResult, {16'h0404, 8'd0, 8'hFF});

    // R1 R2: width 1, stride code 0 steps by 4, upper match bytes ignored
    issue({8'd0, 8'd1, 8'd100, 8'd0}, 32'hAABB_CC40, "R1", 1'b0);
    expect32("R1", "hand stride four hit", lastResult, {16'h0001, 8'd84, 8'd64});

    // R1: width code 3 selects four bytes
    issue({8'd4, 8'd3, 8'd1, 8'd80}, 32'h4433_2211, "R1", 1'b0);

    // R3: count exhausted without a match
    issue({8'd1, 8'd1, 8'd10, 8'd0}, 32'h0000_00EE, "R3", 1'b0);
    expect32("R3", "hand exhaustion", lastResult, {16'h0101, 8'd0, 8'hFF});

    // R8: running off the end of the file
    issue({8'd4, 8'd4, 8'd10, 8'd120}, 32'hDEAD_BEEF, "R8", 1'b0);
    issue({8'd2, 8'd1, 8'd5, 8'd200}, 32'h0000_0000, "R8", 1'b0);
    issue({8'd1, 8'd2, 8'd3, 8'd127}, 32'h0000_0000, "R8", 1'b0);

    // R7: zero field count
    issue({8'd3, 8'd2, 8'd0, 8'd9}, 32'h0000_037F, "R7", 1'b0);
    expect32("R7", "hand empty", lastResult, {16'h0302, 8'd0, 8'hFF});

    // R4: hit on the only field
    issue({8'd1, 8'd2, 8'd1, 8'd37}, 32'h0000_037F, "R4", 1'b0);
    expect32("R4", "hand single hit", lastResult, {16'h0102, 8'd1, 8'd37});

    // R5 R9: mixed patterns against the reference
    for (int t = 0; t < 40; t++) begin
      logic [31:0] mv;
      int          src;
      c   = {8'($urandom_range(0, 5)), 8'($urandom_range(0, 4)),
             8'($urandom_range(0, 50)), 8'($urandom_range(0, 135))};
      src = int'($urandom_range(0, RF_BYTES - 4));
      mv  = {mem[src + 3], mem[src + 2], mem[src + 1], mem[src]};
      if (t % 4 == 3) mv = $urandom;
      issue(c, mv, "R5", 1'b0);
    end

    finishRun();
  end

endmodule